// File: doc/BRIEF.md
# Programmable 16-bit Reload Timer

This block is a down-counting timer that sits beside the channels of a multi-channel serial controller. Software programs it through a small byte-wide register port: two byte registers hold a 16-bit reload value, and a control register selects the tick source, chooses single-shot or re-trigger operation, starts or stops the count and gates the interrupt.

Once started, the counter loads the reload value and steps down by one on every enabled tick. The tick is either every system clock cycle or a cycle in which the alternate tick input is high. When the count ends, an internal event flag is set. In re-trigger mode the counter reloads and runs on. In single-shot mode it rests at zero until software starts it again. The interrupt output is the event flag gated by the interrupt-enable bit. Any read of the control register clears the flag, so the interrupt service routine needs no separate acknowledge write.

Top module: `chan_timer16`

## Requirements
- R1: After reset, all three registers read 0x00, the count output is 0 and the interrupt output is low.
- R2: Address 0 holds reload bits 7:0 and address 1 holds reload bits 15:8. Address 2 is the control register: bit 0 selects the tick source (0 every cycle, 1 the alternate tick input), bit 1 selects re-trigger (1) or single-shot (0), bit 2 is run and bit 3 is interrupt enable. Control bits 7:4 and all of address 3 read as zero. Read data follows the address combinationally.
- R3: A control write with bit 2 set loads the counter from the reload registers at that clock edge, even when the timer is already running. The load takes priority over counting in that cycle.
- R4: While running, each enabled tick lowers the count by one. With the alternate source selected, cycles with the tick input low leave the count unchanged.
- R5: A tick that arrives while the count is 1 (or 0) is the terminal event, and it sets the event flag at the same edge.
- R6: In single-shot mode, the count holds at 0 after the terminal event until the next control write with run set.
- R7: In re-trigger mode, the terminal event reloads the count from the reload registers, giving one event every N ticks for a reload value N of 1 or more.
- R8: A control write with run clear stops counting from the following edge. The edge of that write still applies its tick, and the count then holds.
- R9: The interrupt output is the event flag AND the enable bit. The flag is set by the terminal event whether or not the interrupt is enabled.
- R10: A read strobe at the control address clears the event flag.
- R11: If a clearing read and a terminal event fall on the same edge, the flag stays set.
- R12: Writes to the reload registers do not alter a running count. They take effect at the next load or re-trigger reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; at address 2 it clears the event flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| ext_tick | input | 1 | Alternate tick enable, one tick per high cycle |
| cnt_value | output | 16 | Current count |
| tmr_irq | output | 1 | Interrupt request |

## Verification
The clearing read of the control register and a terminal event can land on the same clock edge. In that case the new event must survive. The bench brings a re-triggering count to 1 and raises the read strobe in exactly that cycle. It then expects the interrupt to still be high, while a lone read one reload period earlier must drop it. A second read after the collision must then clear the interrupt, which shows the flag was really re-set and not merely left untouched.

// File: rtl/ctimer_pkg.sv
// Shared constants and the control register layout for the reload timer.
// Assumes a 2-bit register address and a control field of four bits.
package ctimer_pkg;
    localparam int ADDR_W = 2;
    localparam int CTRL_W = 4;

    localparam logic [ADDR_W-1:0] A_RELOAD_LO = 2'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD_HI = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL      = 2'd2;

    localparam int B_RUN = 2;

    // Control layout, bit 3 down to bit 0.
    typedef struct packed {
        logic irq_en;
        logic run;
        logic retrig;
        logic ext_sel;
    } ctrl_t;
endpackage

// File: rtl/ctimer_regs.sv
// Register file of the timer: two reload bytes and the control register.
// Produces a load strobe for control writes with run set and a clear
// strobe for reads at the control address. Assumes DATA_W >= CTRL_W.
module ctimer_regs
    import ctimer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NBYTES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wr,
    input  logic                     rd,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output logic [NBYTES*DATA_W-1:0] reload,
    output ctrl_t                    ctrl,
    output logic                     load,
    output logic                     clr
);
    logic [DATA_W-1:0] rel_q [NBYTES];
    ctrl_t             ctrl_q;

    // One byte register per reload slice, byte i at address i.
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                rel_q[i] <= '0;
            else if (wr && addr == ADDR_W'(i))
                rel_q[i] <= wdata;
        end
        assign reload[i*DATA_W +: DATA_W] = rel_q[i];
    end

    // Control register capture.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr && addr == A_CTRL)
            ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
    end

    // Read mux; reserved bits and unused addresses return zero.
    always_comb begin
        rdata = '0;
        if (addr == A_CTRL)
            rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        else if (addr == A_RELOAD_LO)
            rdata = rel_q[0];
        else if (addr == A_RELOAD_HI)
            rdata = rel_q[1];
    end

    assign ctrl = ctrl_q;
    assign load = wr && (addr == A_CTRL) && wdata[B_RUN];
    assign clr  = rd && (addr == A_CTRL);

    // R3: a start write leaves run set in the control register.
    p_start_sets_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ctrl_q.run);
endmodule

// File: rtl/ctimer_core.sv
// Down counter with a selectable tick source. Loads on a start strobe,
// steps on enabled ticks and signals the terminal event combinationally
// in the cycle whose edge ends the count. Single-shot expiry is held in
// a rest flag that only a new load releases.
module ctimer_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             retrig,
    input  logic             ext_sel,
    input  logic             ext_tick,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             terminal
);
    logic [CNT_W-1:0] cnt_q;
    logic             rest_q;
    logic             tick_ok;
    logic             adv;
    logic             at_end;

    // Tick qualification and terminal detection.
    always_comb begin
        tick_ok  = ext_sel ? ext_tick : 1'b1;
        adv      = run && !rest_q && tick_ok && !load;
        at_end   = (cnt_q <= CNT_W'(1));
        terminal = adv && at_end;
    end

    // Counter state: load first, then step, reload or come to rest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rest_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= reload;
            rest_q <= 1'b0;
        end else if (adv) begin
            if (!at_end) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end else if (retrig) begin
                cnt_q <= reload;
            end else begin
                cnt_q  <= '0;
                rest_q <= 1'b1;
            end
        end
    end

    assign count = cnt_q;

    // R3: a load takes the reload value present at its edge.
    p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(reload));
    // R4: a qualified tick above the end lowers the count by one.
    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !at_end) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
    // R8: with run clear and no load the count holds.
    p_hold_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt_q));
    // R6: an expired single-shot stays at zero until reloaded.
    p_single_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rest_q && !load) |=> cnt_q == '0);
endmodule

// File: rtl/ctimer_irq.sv
// Event flag and interrupt gating. A terminal event sets the flag; a
// clearing read drops it unless an event lands on the same edge.
module ctimer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic terminal,
    input  logic clr,
    input  logic irq_en,
    output logic irq
);
    logic flag_q;

    // Flag update, the set side taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (terminal)
            flag_q <= 1'b1;
        else if (clr)
            flag_q <= 1'b0;
    end

    assign irq = flag_q && irq_en;

    // R5 and R11: an event always leaves the flag set.
    p_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        terminal |=> flag_q);
    // R10: a clearing read without an event empties the flag.
    p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !terminal) |=> !flag_q);
endmodule

// File: rtl/chan_timer16.sv
// Top of the reload timer: register file, counter and interrupt flag.
// Synchronous active-low reset; one clock domain; the alternate tick
// input is assumed already synchronous to clk.
module chan_timer16
    import ctimer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NBYTES = 2,
    localparam int CNT_W = DATA_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_tick,
    output logic [CNT_W-1:0]  cnt_value,
    output logic              tmr_irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic             load;
    logic             clr;
    logic             terminal;

    ctimer_regs #(.DATA_W(DATA_W), .NBYTES(NBYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .rdata(bus_rdata), .reload(reload), .ctrl(ctrl),
        .load(load), .clr(clr)
    );

    ctimer_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .retrig(ctrl.retrig),
        .ext_sel(ctrl.ext_sel), .ext_tick(ext_tick), .load(load),
        .reload(reload), .count(cnt_value), .terminal(terminal)
    );

    ctimer_irq u_irq (
        .clk(clk), .rst_n(rst_n), .terminal(terminal), .clr(clr),
        .irq_en(ctrl.irq_en), .irq(tmr_irq)
    );
endmodule

// File: tb/tb_chan_timer16.sv
// Directed bench for chan_timer16: one task per scenario, driven and
// sampled on the falling edge.
module tb_chan_timer16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ext_tick = 1'b0;
    logic [15:0] cnt_value;
    logic        tmr_irq;

    int vecs = 0;
    int errs = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    chan_timer16 dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_tick(ext_tick), .cnt_value(cnt_value), .tmr_irq(tmr_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: got 0x%0h, want 0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_tick();
        ext_tick = 1'b1;
        @(negedge clk);
        ext_tick = 1'b0;
    endtask

    task automatic set_reload(input logic [15:0] v);
        wr_reg(2'd0, v[7:0]);
        wr_reg(2'd1, v[15:8]);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 count", cnt_value, 0);
        chk("R1 irq", tmr_irq, 0);
        for (int a = 0; a < 3; a++) begin
            rd_reg(a[1:0], d);
            chk("R1 reg", d, 0);
        end
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        set_reload(16'hA55A);
        rd_reg(2'd0, d); chk("R2 low byte", d, 8'h5A);
        rd_reg(2'd1, d); chk("R2 high byte", d, 8'hA5);
        wr_reg(2'd2, 8'hF2);
        rd_reg(2'd2, d); chk("R2 reserved bits zero", d, 8'h02);
        rd_reg(2'd3, d); chk("R2 address 3 zero", d, 8'h00);
        wr_reg(2'd2, 8'h00);
    endtask

    task automatic t_single();
        logic [7:0] d;
        set_reload(16'd5);
        wr_reg(2'd2, 8'h0C);
        chk("R3 load", cnt_value, 5);
        cyc(4);
        chk("R4 count", cnt_value, 1);
        chk("R5 no early irq", tmr_irq, 0);
        cyc(1);
        chk("R5 terminal irq", tmr_irq, 1);
        chk("R6 at zero", cnt_value, 0);
        cyc(3);
        chk("R6 rests at zero", cnt_value, 0);
        rd_reg(2'd2, d);
        chk("R2 control readback", d, 8'h0C);
        chk("R10 read clears", tmr_irq, 0);
        wr_reg(2'd2, 8'h0C);
        chk("R6 restart loads", cnt_value, 5);
        wr_reg(2'd2, 8'h00);
    endtask

    task automatic t_retrig_collide();
        logic [7:0] d;
        set_reload(16'd3);
        wr_reg(2'd2, 8'h0E);
        chk("R3 load retrig", cnt_value, 3);
        cyc(2);
        chk("R4 count", cnt_value, 1);
        cyc(1);
        chk("R7 reloaded", cnt_value, 3);
        chk("R7 event", tmr_irq, 1);
        rd_reg(2'd2, d);
        chk("R10 read clears", tmr_irq, 0);
        cyc(1);
        chk("R7 running", cnt_value, 1);
        rd_reg(2'd2, d);
        chk("R11 event wins over clear", tmr_irq, 1);
        chk("R7 period", cnt_value, 3);
        rd_reg(2'd2, d);
        chk("R11 flag re-set then cleared", tmr_irq, 0);
        wr_reg(2'd2, 8'h00);
        rd_reg(2'd2, d);
    endtask

    task automatic t_ext_tick();
        logic [7:0] d;
        set_reload(16'd3);
        wr_reg(2'd2, 8'h05);
        chk("R3 load ext", cnt_value, 3);
        cyc(4);
        chk("R4 no tick no step", cnt_value, 3);
        pulse_tick();
        chk("R4 ext step", cnt_value, 2);
        cyc(2);
        pulse_tick();
        pulse_tick();
        chk("R6 ext expiry", cnt_value, 0);
        chk("R9 masked irq", tmr_irq, 0);
        wr_reg(2'd2, 8'h0D);
        chk("R9 flag kept while masked", tmr_irq, 1);
        chk("R3 reload on start", cnt_value, 3);
        rd_reg(2'd2, d);
        chk("R10 clear", tmr_irq, 0);
        wr_reg(2'd2, 8'h00);
    endtask

    task automatic t_stop();
        logic [15:0] held;
        set_reload(16'd20);
        wr_reg(2'd2, 8'h04);
        cyc(3);
        chk("R4 count", cnt_value, 17);
        wr_reg(2'd2, 8'h00);
        chk("R8 stop edge ticks once", cnt_value, 16);
        held = cnt_value;
        cyc(5);
        chk("R8 held", cnt_value, held);
    endtask

    task automatic t_reload_change();
        logic [7:0] d;
        set_reload(16'h0100);
        wr_reg(2'd2, 8'h06);
        chk("R3 load high byte", cnt_value, 256);
        wr_reg(2'd0, 8'h02);
        chk("R12 count undisturbed", cnt_value, 255);
        wr_reg(2'd1, 8'h00);
        chk("R12 count undisturbed", cnt_value, 254);
        cyc(253);
        chk("R4 count", cnt_value, 1);
        cyc(1);
        chk("R12 new reload used", cnt_value, 2);
        wr_reg(2'd2, 8'h00);
        rd_reg(2'd2, d);
    endtask

    initial begin
        repeat (100_000) @(posedge clk);
        if (!finished) begin
            errs++;
            vecs++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_regmap();
        t_single();
        t_retrig_collide();
        t_ext_tick();
        t_stop();
        t_reload_change();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule